// File: doc/BRIEF.md
# Masked Dynamic Trap Priority Unit

This unit holds the processor's interrupt request register and its interrupt mask register. It raises a dynamic trap whenever some bit is both requested and enabled. Each request source has its own set input. Software can clear request bits and can write the mask, and both registers stay visible on read ports. When a trap is pending, the unit names the highest-priority source. Priority falls from bit 0 upward, and the unit reports that source as a binary index and as a one-hot vector.

An eight-bit protection field sits in both registers at offset `PROT_LSB`. Inside the field, the offsets from the field's low end are:

| Offset | Cause |
|---|---|
| 7 | read fault (r) |
| 6 | write fault (w) |
| 5 | execute fault (x) |
| 4 | nonexistent address (n) |
| 3 | key fault (k) |
| 2 | bad instruction (b) |
| 1 | security (s) |
| 0 | privilege (p) |

The instruction being issued supplies its address sign, its class and the protection causes it raises. From these the unit does three things:

- It detects the security rule: code at a non-negative address runs while any mask bit of the protection field is 0.
- It records the protection causes in the request register.
- It tells the memory stage how to suppress the instruction. The unit also returns the raised causes so they can be copied into the saved-execution register.

Top module: `dyn_trap_unit`

## Requirements
- R1: After reset both registers read zero and `trap_o`, `kill_o`, `load_zero_o` and `store_block_o` are 0.
- R2: `trap_o` is 1 exactly when the AND of the request register and the mask register is nonzero. It is combinational from the two registers.
- R3: Among the pending bits (request AND mask), the lowest-numbered one is selected. `trap_idx_o` gives its index and `trap_onehot_o` has only that bit set. Both are zero when nothing is pending.
- R4: A `req_set_i` bit sets its request bit at the next clock. The bit stays set until a `req_clr_i` bit with a 1 clears it at a clock.
- R5: When the same bit is both set and cleared in one cycle, it ends up set.
- R6: With `mask_wr_en_i`=1, the mask takes `mask_wr_data_i` at the next clock. Otherwise it holds, except for R7.
- R7: When `insn_valid_i`=1, `insn_neg_i`=0 and the mask's protection field is not all ones, a security violation occurs. At the next clock, bit `PROT_LSB`+1 is set in both registers. With `insn_neg_i`=1 no violation occurs.
- R8: The causes raised by a valid instruction are its `insn_prot_i` bits, plus s when R7 applies. They are set at the next clock in the request register's protection field, and they are driven on `xx_prot_o` in the same cycle. With no valid instruction, `xx_prot_o` is 0.
- R9: A raised cause is enabled when its mask field bit is 1. The s cause raised by R7 is always enabled. `kill_o` is 1 when x, k or b is an enabled cause.
- R10: `load_zero_o` is 1 for a load (`insn_class_i`=1) with r or n as an enabled cause.
- R11: `store_block_o` is 1 for a store (`insn_class_i`=2) with any enabled cause. It is never 1 for another class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set_i | input | 64 | Per-source request set pulses |
| req_clr_i | input | 64 | Software clear mask for request bits |
| mask_wr_en_i | input | 1 | Software mask write strobe |
| mask_wr_data_i | input | 64 | Software mask write value |
| req_q_o | output | 64 | Request register read port |
| mask_q_o | output | 64 | Mask register read port |
| insn_valid_i | input | 1 | An instruction is issued this cycle |
| insn_neg_i | input | 1 | Sign bit of the instruction address |
| insn_class_i | input | 2 | 0 other, 1 load, 2 store |
| insn_prot_i | input | 8 | Protection causes raised by the instruction (field layout) |
| trap_o | output | 1 | Dynamic trap pending |
| trap_idx_o | output | 6 | Index of the selected pending bit |
| trap_onehot_o | output | 64 | One-hot vector of the selected pending bit |
| kill_o | output | 1 | Instruction must have no effect |
| load_zero_o | output | 1 | Load must return zero |
| store_block_o | output | 1 | Store must write nothing |
| xx_prot_o | output | 8 | Causes to copy into the saved-execution register |

## Verification
The assertions check, on every cycle, these properties:

- The selection is one-hot and no lower pending bit is skipped.
- Set pulses stick in the request register, and no request bit appears without a cause.
- The mask holds unless it is written, and a violation leaves the s bit set in it.
- A store block is raised only for a store.

Some behaviour only the bench's scenarios can show. This covers that the chosen index is the lowest, given specific request and mask patterns. It also covers the interplay of the enable rule with each suppression output, and that a negative address escapes the security rule.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int PROT_W = 8;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_LOAD  = 2'd1,
        CLS_STORE = 2'd2
    } insn_class_e;

    // Protection field, MSB first: read, write, execute, nonexistent,
    // key, bad instruction, security, privilege.
    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic nx;
        logic key;
        logic bad;
        logic sec;
        logic priv;
    } prot_bits_t;

    typedef struct packed {
        logic kill;
        logic load_zero;
        logic store_block;
    } suppress_t;

    localparam prot_bits_t SEC_ONLY = '{sec: 1'b1, default: 1'b0};

    function automatic logic any_noop_cause(prot_bits_t p);
        return p.ex | p.key | p.bad;
    endfunction

    function automatic logic any_zero_load_cause(prot_bits_t p);
        return p.rd | p.nx;
    endfunction

endpackage

// File: rtl/trap_req_reg.sv
module trap_req_reg #(
    parameter int REQ_W    = 64,
    parameter int PROT_LSB = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REQ_W-1:0] set_i,
    input  logic [REQ_W-1:0] clr_i,
    input  logic [7:0]       prot_set_i,
    output logic [REQ_W-1:0] q_o
);
    logic [REQ_W-1:0] hw_set;

    always_comb begin
        hw_set = '0;
        hw_set[PROT_LSB +: 8] = prot_set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= (q_o & ~clr_i) | set_i | hw_set;
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q_o & ~($past(q_o) | $past(set_i) | $past(hw_set))) == '0));

endmodule

// File: rtl/trap_mask_reg.sv
module trap_mask_reg #(
    parameter int REQ_W    = 64,
    parameter int PROT_LSB = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [REQ_W-1:0] wr_data_i,
    input  logic             sec_set_i,
    output logic [REQ_W-1:0] q_o
);
    localparam int SEC_POS = PROT_LSB + 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else begin
            if (wr_en_i) q_o <= wr_data_i;
            if (sec_set_i) q_o[SEC_POS] <= 1'b1;
        end
    end

    // R7
    sec_mask_chk: assert property (@(posedge clk) disable iff (rst)
        sec_set_i |=> q_o[SEC_POS]);

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !sec_set_i) |=> $stable(q_o));

endmodule

// File: rtl/trap_prio_enc.sv
module trap_prio_enc #(
    parameter int REQ_W = 64,
    localparam int IDX_W = $clog2(REQ_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REQ_W-1:0] pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [REQ_W-1:0] onehot_o
);
    always_comb begin
        any_o    = |pend_i;
        onehot_o = pend_i & (~pend_i + 1'b1);
        idx_o    = '0;
        for (int i = REQ_W - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
    end

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(onehot_o));

    // R3
    lower_clear_chk: assert property (@(posedge clk) disable iff (rst)
        any_o |-> ((pend_i & (onehot_o - 1'b1)) == '0));

    // R3
    idx_match_chk: assert property (@(posedge clk) disable iff (rst)
        any_o |-> onehot_o[idx_o]);

endmodule

// File: rtl/trap_suppress.sv
module trap_suppress
    import trap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  insn_class_e class_i,
    input  prot_bits_t  cause_i,
    input  prot_bits_t  enable_i,
    output suppress_t   sup_o
);
    prot_bits_t hit;

    always_comb begin
        hit               = cause_i & enable_i;
        sup_o.kill        = valid_i & any_noop_cause(hit);
        sup_o.load_zero   = valid_i & (class_i == CLS_LOAD) & any_zero_load_cause(hit);
        sup_o.store_block = valid_i & (class_i == CLS_STORE) & (|hit);
    end

    // R11
    store_only_chk: assert property (@(posedge clk) disable iff (rst)
        sup_o.store_block |-> (class_i == CLS_STORE));

    // R10
    load_only_chk: assert property (@(posedge clk) disable iff (rst)
        sup_o.load_zero |-> (class_i == CLS_LOAD));

endmodule

// File: rtl/dyn_trap_unit.sv
module dyn_trap_unit
    import trap_pkg::*;
#(
    parameter int REQ_W    = 64,
    parameter int PROT_LSB = 32,
    localparam int IDX_W   = $clog2(REQ_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REQ_W-1:0] req_set_i,
    input  logic [REQ_W-1:0] req_clr_i,
    input  logic             mask_wr_en_i,
    input  logic [REQ_W-1:0] mask_wr_data_i,
    output logic [REQ_W-1:0] req_q_o,
    output logic [REQ_W-1:0] mask_q_o,
    input  logic             insn_valid_i,
    input  logic             insn_neg_i,
    input  logic [1:0]       insn_class_i,
    input  logic [7:0]       insn_prot_i,
    output logic             trap_o,
    output logic [IDX_W-1:0] trap_idx_o,
    output logic [REQ_W-1:0] trap_onehot_o,
    output logic             kill_o,
    output logic             load_zero_o,
    output logic             store_block_o,
    output logic [7:0]       xx_prot_o
);
    prot_bits_t  mask_field;
    prot_bits_t  cause;
    prot_bits_t  enable;
    logic        sec_viol;
    suppress_t   sup;
    insn_class_e cls;

    always_comb begin
        mask_field = prot_bits_t'(mask_q_o[PROT_LSB +: PROT_W]);
        sec_viol   = insn_valid_i & ~insn_neg_i & (mask_field != prot_bits_t'('1));
        cause      = insn_valid_i ? (prot_bits_t'(insn_prot_i) | (sec_viol ? SEC_ONLY : prot_bits_t'('0)))
                                  : prot_bits_t'('0);
        enable     = mask_field | (sec_viol ? SEC_ONLY : prot_bits_t'('0));
        cls        = insn_class_e'(insn_class_i);
    end

    trap_req_reg #(.REQ_W(REQ_W), .PROT_LSB(PROT_LSB)) u_req (
        .clk        (clk),
        .rst        (rst),
        .set_i      (req_set_i),
        .clr_i      (req_clr_i),
        .prot_set_i (cause),
        .q_o        (req_q_o)
    );

    trap_mask_reg #(.REQ_W(REQ_W), .PROT_LSB(PROT_LSB)) u_mask (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (mask_wr_en_i),
        .wr_data_i (mask_wr_data_i),
        .sec_set_i (sec_viol),
        .q_o       (mask_q_o)
    );

    trap_prio_enc #(.REQ_W(REQ_W)) u_prio (
        .clk      (clk),
        .rst      (rst),
        .pend_i   (req_q_o & mask_q_o),
        .any_o    (trap_o),
        .idx_o    (trap_idx_o),
        .onehot_o (trap_onehot_o)
    );

    trap_suppress u_sup (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (insn_valid_i),
        .class_i  (cls),
        .cause_i  (cause),
        .enable_i (enable),
        .sup_o    (sup)
    );

    assign kill_o        = sup.kill;
    assign load_zero_o   = sup.load_zero;
    assign store_block_o = sup.store_block;
    assign xx_prot_o     = cause;

    // R2
    trap_pend_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> ((req_q_o & mask_q_o) != '0));

endmodule

// File: tb/dyn_trap_unit_test.sv
module dyn_trap_unit_test;
    localparam int PL = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] req_set, req_clr, mask_data;
    logic        mask_wr, valid, neg;
    logic [1:0]  cls;
    logic [7:0]  prot;
    logic [63:0] req_q, mask_q, onehot;
    logic        trap, kill, lzero, sblock;
    logic [5:0]  idx;
    logic [7:0]  xx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dyn_trap_unit uut (
        .clk(clk), .rst(rst),
        .req_set_i(req_set), .req_clr_i(req_clr),
        .mask_wr_en_i(mask_wr), .mask_wr_data_i(mask_data),
        .req_q_o(req_q), .mask_q_o(mask_q),
        .insn_valid_i(valid), .insn_neg_i(neg),
        .insn_class_i(cls), .insn_prot_i(prot),
        .trap_o(trap), .trap_idx_o(idx), .trap_onehot_o(onehot),
        .kill_o(kill), .load_zero_o(lzero), .store_block_o(sblock),
        .xx_prot_o(xx)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_set = '0; req_clr = '0; mask_wr = 1'b0; mask_data = '0;
        valid = 1'b0; neg = 1'b0; cls = 2'd0; prot = '0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        idle();
        #1;
    endtask

    task automatic write_mask(input logic [63:0] m);
        mask_wr = 1'b1; mask_data = m;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 req", req_q, '0);
        chk("R1 mask", mask_q, '0);
        chk("R1 trap", {63'd0, trap}, 64'd0);
        chk("R1 supp", {61'd0, kill, lzero, sblock}, 64'd0);
    endtask

    task automatic t_pending();
        req_set = 64'd1 << 10;
        tick();
        chk("R4 set", req_q, 64'd1 << 10);
        chk("R2 masked off", {63'd0, trap}, 64'd0);
        write_mask(64'd1 << 10);
        chk("R6 mask write", mask_q, 64'd1 << 10);
        chk("R2 trap", {63'd0, trap}, 64'd1);
        chk("R3 idx", {58'd0, idx}, 64'd10);
    endtask

    task automatic t_priority();
        req_set = (64'd1 << 3) | (64'd1 << 7) | (64'd1 << 40);
        write_mask('1);
        tick();
        chk("R3 lowest idx", {58'd0, idx}, 64'd3);
        chk("R3 onehot", onehot, 64'd1 << 3);
        write_mask(~(64'd1 << 3));
        chk("R3 next idx", {58'd0, idx}, 64'd7);
        write_mask(64'd1 << 40);
        chk("R3 high idx", {58'd0, idx}, 64'd40);
        write_mask(64'd1 << 63);
        chk("R3 none onehot", onehot, 64'd0);
        chk("R3 none idx", {58'd0, idx}, 64'd0);
    endtask

    task automatic t_clear();
        req_clr = 64'd1 << 3;
        tick();
        chk("R4 clear", req_q & (64'd1 << 3), 64'd0);
        chk("R4 others stay", req_q & (64'd1 << 7), 64'd1 << 7);
        req_set = 64'd1 << 7; req_clr = 64'd1 << 7;
        tick();
        chk("R5 set wins", req_q & (64'd1 << 7), 64'd1 << 7);
        req_clr = '1;
        tick();
        chk("R4 clear all", req_q, 64'd0);
    endtask

    task automatic t_security();
        logic [63:0] m;
        m = ~((64'd1 << (PL + 7)) | (64'd1 << (PL + 1)));
        write_mask(m);
        valid = 1'b1; neg = 1'b1; cls = 2'd2; prot = '0;
        #1;
        chk("R7 neg no block", {63'd0, sblock}, 64'd0);
        chk("R8 neg xx", {56'd0, xx}, 64'd0);
        tick();
        chk("R7 neg no set", req_q, 64'd0);
        chk("R7 neg mask kept", mask_q, m);
        valid = 1'b1; neg = 1'b0; cls = 2'd2; prot = '0;
        #1;
        chk("R11 sec block", {63'd0, sblock}, 64'd1);
        chk("R9 sec no kill", {63'd0, kill}, 64'd0);
        chk("R8 sec xx", {56'd0, xx}, 64'h02);
        tick();
        chk("R7 req s", req_q, 64'd1 << (PL + 1));
        chk("R7 mask s", mask_q, m | (64'd1 << (PL + 1)));
        valid = 1'b1; neg = 1'b0; cls = 2'd1; prot = 8'h80;
        #1;
        chk("R10 r disabled", {63'd0, lzero}, 64'd0);
        chk("R11 load no block", {63'd0, sblock}, 64'd0);
        tick();
        req_clr = '1;
        tick();
    endtask

    task automatic t_suppress();
        write_mask('1);
        valid = 1'b1; cls = 2'd0; prot = 8'h20;
        #1;
        chk("R9 x kill", {63'd0, kill}, 64'd1);
        chk("R8 xx", {56'd0, xx}, 64'h20);
        prot = 8'h04; cls = 2'd1;
        #1;
        chk("R9 b kill", {63'd0, kill}, 64'd1);
        chk("R10 b no zero", {63'd0, lzero}, 64'd0);
        prot = 8'h80; cls = 2'd1;
        #1;
        chk("R10 r zero", {63'd0, lzero}, 64'd1);
        chk("R9 r no kill", {63'd0, kill}, 64'd0);
        prot = 8'h10; cls = 2'd0;
        #1;
        chk("R10 n other", {63'd0, lzero}, 64'd0);
        prot = 8'h40; cls = 2'd2;
        #1;
        chk("R11 w block", {63'd0, sblock}, 64'd1);
        prot = 8'h40; cls = 2'd1;
        #1;
        chk("R11 w load", {62'd0, sblock, lzero}, 64'd0);
        tick();
        chk("R8 req field", req_q, 64'h40 << PL);
        chk("R2 trap on cause", {58'd0, trap, idx}, {58'd0, 1'b1, 6'(PL + 6)});
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        t_reset();
        t_pending();
        t_priority();
        t_clear();
        t_security();
        t_suppress();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule